// File: doc/BRIEF.md
# Register-Result Integer ALU

This block is the arithmetic and logic unit of a three-address, load/store integer core. It takes two operand words and a 4-bit operation select, and it returns the result word combinationally in the same cycle. Operand choice, including any sign-extended immediate, is made by the surrounding datapath before the operands arrive. The block supports add, subtract, multiply, divide, bitwise logic, six signed relational compares and two shifts. A compare writes a full register value of 0 or 1 and does not set a dedicated condition flag.

Four status bits sit in a small flag register: zero, sign, carry and overflow. On a clock edge with `flag_we` high, the block updates only the bits that belong to the current operation's group. Every other bit keeps its value. The result word and the flag inputs are plain combinational paths driven by the core's own control, so no handshake is involved. The core applies a select and operands, reads `result` in the same cycle, and asserts `flag_we` when that instruction may touch the status bits.

Top module: `rr_alu`

## Requirements
- R1: Select 0 (add) returns a+b modulo 2^32, and the carry bit becomes the carry out of bit 31. Select 1 (sub) returns a-b modulo 2^32, and the carry bit becomes 1 exactly when a < b as unsigned values (a borrow).
- R2: Add and sub update only the zero and carry bits. The sign and overflow bits keep their values.
- R3: Select 2 (mul) returns the low 32 bits of the signed product. The overflow bit is set when the signed 64-bit product lies outside the signed 32-bit range. Mul and select 3 (div) update only the zero and overflow bits.
- R4: Div is signed and truncates toward zero. A zero divisor gives a result of 0 with overflow set. The most negative value divided by -1 gives the most negative value with overflow set.
- R5: Selects 4, 5 and 6 return the bitwise and, or and xor of the operands.
- R6: Selects 7 to 12 (eq, ne, lt, le, gt, ge) compare the operands as signed 32-bit integers. The result is exactly 1 for true and 0 for false.
- R7: Select 13 (shl) shifts a left and select 14 (shr) shifts a right, filling with zeros. The shift amount is taken from b[4:0] only.
- R8: Selects 4 to 14 update only the zero and sign bits. The carry and overflow bits keep their values. The sign bit is result bit 31.
- R9: With `flag_we` low, no status bit changes at a clock edge, whatever the select.
- R10: Select 15 returns a result of 0 and changes no status bit, even with `flag_we` high.
- R11: An active-low `rst_n` clears all four status bits. Zero is set when the result word is all zeros.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Asynchronous active-low reset of the status bits |
| op_sel | input | 4 | Operation select, codes 0..15 |
| opa | input | 32 | First operand |
| opb | input | 32 | Second operand (also supplies the shift amount) |
| flag_we | input | 1 | Allows the status bits of the current group to update at the clock edge |
| result | output | 32 | Combinational result word |
| z_flag | output | 1 | Registered zero bit |
| s_flag | output | 1 | Registered sign bit |
| c_flag | output | 1 | Registered carry/borrow bit |
| v_flag | output | 1 | Registered overflow bit |

## Verification
The bench builds the block with its default 32-bit width. At that width the real boundary values can be driven directly: the most negative word divided by -1, products that overflow to an all-zero low word, shifts by 31, and a shift operand of 33 whose upper bits must be ignored. The bench runs a reference model of the status register alongside the block. It orders the operations so that each hold rule is exercised: a set sign bit surviving an add, a set carry bit surviving a logic operation, and a write-disabled cycle following one that would have changed every bit.

// File: rtl/rr_alu_pkg.sv
package rr_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_SUB  = 4'd1,
    OP_MUL  = 4'd2,
    OP_DIV  = 4'd3,
    OP_AND  = 4'd4,
    OP_OR   = 4'd5,
    OP_XOR  = 4'd6,
    OP_EQ   = 4'd7,
    OP_NE   = 4'd8,
    OP_LT   = 4'd9,
    OP_LE   = 4'd10,
    OP_GT   = 4'd11,
    OP_GE   = 4'd12,
    OP_SHL  = 4'd13,
    OP_SHR  = 4'd14,
    OP_IDLE = 4'd15
  } alu_op_e;

  localparam int NFLAG = 4;
  // status vector layout {zero, sign, carry, overflow}
  localparam int FZ = 3;
  localparam int FS = 2;
  localparam int FC = 1;
  localparam int FV = 0;

  function automatic logic [NFLAG-1:0] flag_mask(alu_op_e op);
    logic [NFLAG-1:0] m;
    m = '0;
    case (op)
      OP_ADD, OP_SUB: begin m[FZ] = 1'b1; m[FC] = 1'b1; end
      OP_MUL, OP_DIV: begin m[FZ] = 1'b1; m[FV] = 1'b1; end
      OP_IDLE:        m = '0;
      default:        begin m[FZ] = 1'b1; m[FS] = 1'b1; end
    endcase
    return m;
  endfunction

endpackage

// File: rtl/rr_alu_arith.sv
module rr_alu_arith
  import rr_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res,
  output logic             carry,
  output logic             ovf
);
  localparam int PW = 2 * WIDTH;
  localparam logic [WIDTH-1:0] MINV = {1'b1, {(WIDTH-1){1'b0}}};

  logic [WIDTH:0]   sum_ext;
  logic [WIDTH:0]   dif_ext;
  logic [PW-1:0]    prod;
  logic             prod_ovf;
  logic [WIDTH-1:0] mag_a, mag_b, mag_bs, mag_q, quot;
  logic             q_neg, div_zero, div_wrap;

  assign sum_ext = {1'b0, a} + {1'b0, b};
  assign dif_ext = {1'b0, a} - {1'b0, b};

  // low 2W bits of an unsigned product of sign-extended operands equal the signed product
  assign prod = {{WIDTH{a[WIDTH-1]}}, a} * {{WIDTH{b[WIDTH-1]}}, b};
  assign prod_ovf = !((&prod[PW-1:WIDTH-1]) || (~|prod[PW-1:WIDTH-1]));

  // signed division through magnitudes, truncating toward zero
  assign mag_a    = a[WIDTH-1] ? (~a + 1'b1) : a;
  assign mag_b    = b[WIDTH-1] ? (~b + 1'b1) : b;
  assign div_zero = (b == '0);
  assign mag_bs   = div_zero ? {{(WIDTH-1){1'b0}}, 1'b1} : mag_b;
  assign mag_q    = mag_a / mag_bs;
  assign q_neg    = a[WIDTH-1] ^ b[WIDTH-1];
  assign quot     = q_neg ? (~mag_q + 1'b1) : mag_q;
  assign div_wrap = (a == MINV) && (&b);

  always_comb begin
    res   = '0;
    carry = 1'b0;
    ovf   = 1'b0;
    case (op)
      OP_ADD: begin res = sum_ext[WIDTH-1:0]; carry = sum_ext[WIDTH]; end
      OP_SUB: begin res = dif_ext[WIDTH-1:0]; carry = dif_ext[WIDTH]; end
      OP_MUL: begin res = prod[WIDTH-1:0];    ovf   = prod_ovf;       end
      OP_DIV: begin
        res = div_zero ? '0 : quot;
        ovf = div_zero || div_wrap;
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/rr_alu_logic.sv
module rr_alu_logic
  import rr_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  alu_op_e          op,
  input  logic [WIDTH-1:0] a,
  input  logic [WIDTH-1:0] b,
  output logic [WIDTH-1:0] res
);
  localparam int SHW = $clog2(WIDTH);

  logic [SHW-1:0] shamt;
  logic           lt_s, eq_v;

  assign shamt = b[SHW-1:0];
  assign lt_s  = $signed(a) < $signed(b);
  assign eq_v  = (a == b);

  function automatic logic [WIDTH-1:0] bool_word(logic t);
    return {{(WIDTH-1){1'b0}}, t};
  endfunction

  always_comb begin
    res = '0;
    case (op)
      OP_AND: res = a & b;
      OP_OR:  res = a | b;
      OP_XOR: res = a ^ b;
      OP_EQ:  res = bool_word(eq_v);
      OP_NE:  res = bool_word(!eq_v);
      OP_LT:  res = bool_word(lt_s);
      OP_LE:  res = bool_word(lt_s || eq_v);
      OP_GT:  res = bool_word(!lt_s && !eq_v);
      OP_GE:  res = bool_word(!lt_s);
      OP_SHL: res = a << shamt;
      OP_SHR: res = a >> shamt;
      default: ;
    endcase
  end
endmodule

// File: rtl/rr_alu_flags.sv
module rr_alu_flags
  import rr_alu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we,
  input  logic [NFLAG-1:0] upd_mask,
  input  logic [NFLAG-1:0] new_flags,
  output logic [NFLAG-1:0] flags_q
);
  for (genvar i = 0; i < NFLAG; i++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 flags_q[i] <= 1'b0;
      else if (we && upd_mask[i]) flags_q[i] <= new_flags[i];
    end
  end
endmodule

// File: rtl/rr_alu.sv
module rr_alu
  import rr_alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [3:0]       op_sel,
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             flag_we,
  output logic [WIDTH-1:0] result,
  output logic             z_flag,
  output logic             s_flag,
  output logic             c_flag,
  output logic             v_flag
);
  alu_op_e          op;
  logic [WIDTH-1:0] ar_res, lg_res;
  logic             ar_carry, ar_ovf;
  logic [NFLAG-1:0] nxt_flags, flags_q;

  assign op = alu_op_e'(op_sel);

  rr_alu_arith #(.WIDTH(WIDTH)) u_arith (
    .op(op), .a(opa), .b(opb), .res(ar_res), .carry(ar_carry), .ovf(ar_ovf)
  );

  rr_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .op(op), .a(opa), .b(opb), .res(lg_res)
  );

  always_comb begin
    if (op_sel <= 4'd3)       result = ar_res;
    else if (op_sel <= 4'd14) result = lg_res;
    else                      result = '0;
  end

  always_comb begin
    nxt_flags     = '0;
    nxt_flags[FZ] = (result == '0);
    nxt_flags[FS] = result[WIDTH-1];
    nxt_flags[FC] = ar_carry;
    nxt_flags[FV] = ar_ovf;
  end

  rr_alu_flags u_flags (
    .clk(clk), .rst_n(rst_n), .we(flag_we),
    .upd_mask(flag_mask(op)), .new_flags(nxt_flags), .flags_q(flags_q)
  );

  assign z_flag = flags_q[FZ];
  assign s_flag = flags_q[FS];
  assign c_flag = flags_q[FC];
  assign v_flag = flags_q[FV];
endmodule

// File: rtl/rr_alu_chk.sv
module rr_alu_chk #(
  parameter int WIDTH = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic [3:0]       op_sel,
  input logic [WIDTH-1:0] opb,
  input logic             flag_we,
  input logic [WIDTH-1:0] result,
  input logic             z_flag,
  input logic             s_flag,
  input logic             c_flag,
  input logic             v_flag
);
  a_r1_zero_after_add: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_sel == 4'd0) |=> (z_flag == ($past(result) == '0)));

  a_r2_sign_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_sel <= 4'd1) |=> ($stable(s_flag) && $stable(v_flag)));

  a_r3_carry_sign_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && (op_sel == 4'd2 || op_sel == 4'd3)) |=> ($stable(c_flag) && $stable(s_flag)));

  a_r4_div_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd3 && opb == '0) |-> (result == '0));

  a_r6_bool_word: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel >= 4'd7 && op_sel <= 4'd12) |-> (result[WIDTH-1:1] == '0));

  a_r8_carry_ovf_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (flag_we && op_sel >= 4'd4 && op_sel <= 4'd14) |=> ($stable(c_flag) && $stable(v_flag)));

  a_r9_write_off: assert property (@(posedge clk) disable iff (!rst_n)
    !flag_we |=> $stable({z_flag, s_flag, c_flag, v_flag}));

  a_r10_idle_select: assert property (@(posedge clk) disable iff (!rst_n)
    (op_sel == 4'd15) |=> $stable({z_flag, s_flag, c_flag, v_flag}));
endmodule

bind rr_alu rr_alu_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opb(opb), .flag_we(flag_we),
  .result(result), .z_flag(z_flag), .s_flag(s_flag), .c_flag(c_flag), .v_flag(v_flag)
);

// File: tb/rr_alu_tb.sv
module rr_alu_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  op_sel = 4'd15;
  logic [31:0] opa = '0, opb = '0;
  logic        flag_we = 1'b0;
  logic [31:0] result;
  logic        z_flag, s_flag, c_flag, v_flag;

  int n_cmp = 0, n_bad = 0;
  logic [3:0] mflags = 4'b0000; // {z,s,c,v}

  typedef struct {
    logic [31:0] r;
    logic [3:0]  f;
    string       tag;
  } item_t;
  item_t sb_q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  rr_alu u_dut (
    .clk(clk), .rst_n(rst_n), .op_sel(op_sel), .opa(opa), .opb(opb),
    .flag_we(flag_we), .result(result), .z_flag(z_flag), .s_flag(s_flag),
    .c_flag(c_flag), .v_flag(v_flag)
  );

  // reference model built from the requirements
  function automatic logic [31:0] ref_res(int op, logic [31:0] a, logic [31:0] b);
    longint sa, sb;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    case (op)
      0: return a + b;
      1: return a - b;
      2: return 32'(sa * sb);
      3: return (b == 0) ? 32'd0 : 32'(sa / sb);
      4: return a & b;
      5: return a | b;
      6: return a ^ b;
      7: return {31'd0, sa == sb};
      8: return {31'd0, sa != sb};
      9: return {31'd0, sa < sb};
      10: return {31'd0, sa <= sb};
      11: return {31'd0, sa > sb};
      12: return {31'd0, sa >= sb};
      13: return a << b[4:0];
      14: return a >> b[4:0];
      default: return 32'd0;
    endcase
  endfunction

  function automatic logic [3:0] ref_flags(int op, logic [31:0] a, logic [31:0] b,
                                           logic [3:0] old);
    logic [31:0] r;
    logic [3:0]  f;
    longint sa, sb, p;
    r = ref_res(op, a, b);
    f = old;
    sa = longint'($signed(a));
    sb = longint'($signed(b));
    if (op <= 1) begin
      f[3] = (r == 0);
      f[1] = (op == 0) ? (({1'b0, a} + {1'b0, b}) > 33'hFFFFFFFF) : (a < b);
    end else if (op <= 3) begin
      f[3] = (r == 0);
      if (op == 2) p = sa * sb;
      else         p = (b == 0) ? 0 : sa / sb;
      f[0] = (op == 3 && b == 0) || (p > 64'sd2147483647) || (p < -64'sd2147483648);
    end else if (op <= 14) begin
      f[3] = (r == 0);
      f[2] = r[31];
    end
    return f;
  endfunction

  task automatic drive(int op, logic [31:0] a, logic [31:0] b, logic we, string tag);
    item_t it;
    @(negedge clk);
    op_sel  = 4'(op);
    opa     = a;
    opb     = b;
    flag_we = we;
    it.r = ref_res(op, a, b);
    if (we) mflags = ref_flags(op, a, b, mflags);
    it.f   = mflags;
    it.tag = tag;
    sb_q.push_back(it);
  endtask

  // monitor: result is combinational, flags settle at the following edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        n_cmp++;
        if (result !== it.r || {z_flag, s_flag, c_flag, v_flag} !== it.f) begin
          n_bad++;
          $display("FAIL %s: result=%h flags=%b expected result=%h flags=%b",
                   it.tag, result, {z_flag, s_flag, c_flag, v_flag}, it.r, it.f);
        end
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    n_cmp++;
    if ({z_flag, s_flag, c_flag, v_flag} !== 4'b0000) begin
      n_bad++;
      $display("FAIL R11 reset: flags=%b expected=0000", {z_flag, s_flag, c_flag, v_flag});
    end
    rst_n = 1'b1;

    // R1 add/sub with carry and borrow
    drive(0, 32'd5, 32'd7, 1'b1, "R1 add small");
    drive(0, 32'hFFFFFFFF, 32'd1, 1'b1, "R1 add carry out, R11 zero");
    drive(1, 32'd3, 32'd5, 1'b1, "R1 sub borrow");
    drive(1, 32'd9, 32'd9, 1'b1, "R1 sub equal zero");
    // R2 sign and overflow held across add/sub
    drive(6, 32'h80000000, 32'd0, 1'b1, "R8 xor sets sign");
    drive(2, 32'h00010000, 32'h00010000, 1'b1, "R3 mul overflow low zero");
    drive(0, 32'd1, 32'd2, 1'b1, "R2 add keeps sign and overflow");
    drive(1, 32'd0, 32'd1, 1'b1, "R2 sub keeps sign and overflow");
    // R3 multiply
    drive(2, 32'd6, 32'hFFFFFFF9, 1'b1, "R3 mul negative");
    drive(2, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, "R3 mul -1*-1");
    drive(2, 32'h40000000, 32'd2, 1'b1, "R3 mul positive overflow");
    // R4 divide
    drive(3, 32'd7, 32'd2, 1'b1, "R4 div 7/2");
    drive(3, 32'hFFFFFFF9, 32'd2, 1'b1, "R4 div -7/2 truncates");
    drive(3, 32'd7, 32'hFFFFFFFE, 1'b1, "R4 div 7/-2");
    drive(3, 32'd5, 32'd0, 1'b1, "R4 div by zero");
    drive(3, 32'h80000000, 32'hFFFFFFFF, 1'b1, "R4 div min/-1");
    // R5 bitwise, R8 carry kept
    drive(0, 32'hFFFFFFFF, 32'd2, 1'b1, "R1 add sets carry");
    drive(4, 32'hF0F0F0F0, 32'h0FF00FF0, 1'b1, "R5 and, R8 carry held");
    drive(5, 32'hF0F0F0F0, 32'h0F0F0F0F, 1'b1, "R5 or");
    drive(6, 32'h12345678, 32'h12345678, 1'b1, "R5 xor to zero");
    // R6 compares
    drive(9, 32'hFFFFFFFF, 32'd1, 1'b1, "R6 lt signed true");
    drive(11, 32'hFFFFFFFF, 32'd1, 1'b1, "R6 gt signed false");
    drive(7, 32'd42, 32'd42, 1'b1, "R6 eq true");
    drive(8, 32'd42, 32'd42, 1'b1, "R6 ne false");
    drive(10, 32'h80000000, 32'h80000000, 1'b1, "R6 le equal");
    drive(12, 32'd0, 32'h80000000, 1'b1, "R6 ge");
    // R7 shifts
    drive(13, 32'd1, 32'd31, 1'b1, "R7 shl by 31");
    drive(14, 32'h80000000, 32'd31, 1'b1, "R7 shr logical");
    drive(13, 32'd3, 32'd33, 1'b1, "R7 shl uses low five bits");
    drive(14, 32'hF0000000, 32'd4, 1'b1, "R7 shr zero fill");
    // R9 write disabled, R10 idle select
    drive(2, 32'h40000000, 32'd4, 1'b1, "R3 mul overflow before hold");
    drive(1, 32'd0, 32'd0, 1'b0, "R9 write off keeps flags");
    drive(6, 32'h80000000, 32'd0, 1'b0, "R9 write off logic");
    drive(15, 32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, "R10 idle select");
    drive(15, 32'd0, 32'd0, 1'b1, "R10 idle select zero operands");

    @(negedge clk);
    flag_we = 1'b0;
    op_sel  = 4'd15;
    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule